// File: doc/BRIEF.md
# CSR Access Checker with Read-Modify-Write Merge

This block executes control-and-status register instructions on behalf of a processor pipeline. The decoder hands it a 12-bit register address, the hart's current privilege level, the 3-bit operation field of the instruction, the source-register operand and the 5-bit immediate. The block presents the address to the register bank, which answers in the same cycle with the register's current contents and four qualifiers: present, writable, read fault and write fault.

From the operation the block forms a write mask and write data. It judges legality from the address encoding and the bank qualifiers, and merges the old contents with the data under the mask. One cycle after the request it returns a response: either the old value, or an illegal-access flag for the pipeline to turn into an exception. When a legal access has a nonzero mask and a writable target, it also issues a single-cycle write strobe with the merged value.

A set or clear whose mask is zero writes nothing. Such an access therefore never trips the read-only rule, so software can read read-only registers with it.

Top module: `csr_rmw_unit`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high exactly one clock later, and a cycle with `req_valid` low produces `rsp_valid` low one clock later. All outputs are 0 while reset is applied.
- R2: Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine. Address bits [9:8] give the lowest privilege allowed to access the register, and any request whose `req_priv` is numerically below that value is illegal, whatever its mask.
- R3: Addresses with bits [11:10] equal to 2'b11 are read-only. A request to one of them with a nonzero write mask is illegal, and a request to one of them with a zero mask is legal.
- R4: Operation 3'b001 uses an all-ones mask with the operand as data. Operation 3'b010 uses the operand as mask with all-ones data. Operation 3'b011 uses the operand as mask with zero data. The written value is (old AND NOT mask) OR (data AND mask).
- R5: Operations 3'b101, 3'b110 and 3'b111 behave as 3'b001, 3'b010 and 3'b011 respectively, but take `req_uimm` zero-extended as the operand and ignore `req_operand`.
- R6: A request to an address with `bank_present` low is illegal.
- R7: When `bank_writable` is low, a legal request issues no write, still succeeds, and returns the old value.
- R8: `bank_rd_fault` high makes a request illegal. `bank_wr_fault` high makes a request illegal only when a write would otherwise be issued, that is when the mask is nonzero and the target is writable.
- R9: A legal response carries the register contents sampled in the request cycle, before any write. An illegal response carries zero data.
- R10: `wr_en` is high only in a response cycle that is legal. A set or clear whose mask is zero, including an immediate of 0, issues no write. When `wr_en` is high, `wr_addr` equals the request address.
- R11: Operation codes 3'b000 and 3'b100 are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | CSR address |
| req_priv | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| req_op | input | 3 | Operation field of the instruction |
| req_operand | input | XLEN | Source register value |
| req_uimm | input | IMM_W | Immediate operand for the immediate forms |
| bank_addr | output | 12 | Address presented to the register bank |
| bank_rdata | input | XLEN | Current contents of the addressed register |
| bank_present | input | 1 | A readable register exists at the address |
| bank_writable | input | 1 | The register has a write path |
| bank_rd_fault | input | 1 | The register's own read check refuses the access |
| bank_wr_fault | input | 1 | The register's own write check refuses the access |
| rsp_valid | output | 1 | Response valid |
| rsp_illegal | output | 1 | Access is illegal |
| rsp_rdata | output | XLEN | Old register value |
| wr_en | output | 1 | Write strobe to the bank |
| wr_addr | output | 12 | Write address |
| wr_data | output | XLEN | Merged value to write |

## Verification
The bench builds the block with XLEN of 32 and IMM_W of 5. With that width, hand-picked old values and operands make every mask bit pattern visible in a 32-bit word, and the immediate forms show the zero extension above bit 4. The 12-bit address lets the table reach every combination of privilege field and read-only field. Register images and qualifiers come straight from the table, so fault, missing and write-less targets are easy to produce.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  localparam int CSR_ADDR_W  = 12;
  // address fields that the access rules decode
  localparam int PRIV_FLD_LO = 8;
  localparam int RO_FLD_LO   = 10;

  typedef enum logic [2:0] {
    OPC_RSV0 = 3'b000,
    OPC_RW   = 3'b001,
    OPC_RS   = 3'b010,
    OPC_RC   = 3'b011,
    OPC_RSV4 = 3'b100,
    OPC_RWI  = 3'b101,
    OPC_RSI  = 3'b110,
    OPC_RCI  = 3'b111
  } csr_opc_e;

  typedef struct packed {
    logic illegal;
    logic do_write;
  } acc_verdict_t;

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/csr_op_decode.sv
module csr_op_decode #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 5
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] operand,
  input  logic [IMM_W-1:0] uimm,
  output logic            op_ok,
  output logic [XLEN-1:0] wmask,
  output logic [XLEN-1:0] wdata,
  output logic            mask_nz
);
  import csr_rmw_pkg::*;

  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] src;

  // immediate forms select the zero-extended immediate
  always_comb begin
    if (op[2]) src = {{PAD_W{1'b0}}, uimm};
    else       src = operand;
  end

  always_comb begin
    op_ok = 1'b1;
    wmask = '0;
    wdata = '0;
    unique case (csr_opc_e'(op))
      OPC_RW, OPC_RWI: begin
        wmask = '1;
        wdata = src;
      end
      OPC_RS, OPC_RSI: begin
        wmask = src;
        wdata = '1;
      end
      OPC_RC, OPC_RCI: begin
        wmask = src;
        wdata = '0;
      end
      default: begin
        op_ok = 1'b0;
      end
    endcase
  end

  assign mask_nz = |wmask;
endmodule

// File: rtl/csr_access_check.sv
module csr_access_check (
  input  logic [3:0] addr_hi,
  input  logic [1:0] priv,
  input  logic       op_ok,
  input  logic       mask_nz,
  input  logic       present,
  input  logic       writable,
  input  logic       rd_fault,
  input  logic       wr_fault,
  output csr_rmw_pkg::acc_verdict_t verdict
);
  import csr_rmw_pkg::*;

  localparam int OFS_PRIV = PRIV_FLD_LO - 8;
  localparam int OFS_RO   = RO_FLD_LO - 8;

  logic [1:0] min_priv;
  logic       read_only;
  logic       want_write;
  logic       deny_priv;
  logic       deny_ro;
  logic       deny_bank;

  always_comb begin
    min_priv   = addr_hi[OFS_PRIV +: 2];
    read_only  = (addr_hi[OFS_RO +: 2] == 2'b11);
    want_write = mask_nz && writable;
    deny_priv  = (priv < min_priv);
    deny_ro    = read_only && mask_nz;
    deny_bank  = !present || rd_fault || (want_write && wr_fault);
    verdict.illegal  = !op_ok || deny_priv || deny_ro || deny_bank;
    verdict.do_write = want_write && !verdict.illegal;
  end
endmodule

// File: rtl/csr_merge.sv
module csr_merge #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wmask,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] new_val
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    assign new_val[b] = wmask[b] ? wdata[b] : old_val[b];
  end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [11:0]      req_addr,
  input  logic [1:0]       req_priv,
  input  logic [2:0]       req_op,
  input  logic [XLEN-1:0]  req_operand,
  input  logic [IMM_W-1:0] req_uimm,
  output logic [11:0]      bank_addr,
  input  logic [XLEN-1:0]  bank_rdata,
  input  logic             bank_present,
  input  logic             bank_writable,
  input  logic             bank_rd_fault,
  input  logic             bank_wr_fault,
  output logic             rsp_valid,
  output logic             rsp_illegal,
  output logic [XLEN-1:0]  rsp_rdata,
  output logic             wr_en,
  output logic [11:0]      wr_addr,
  output logic [XLEN-1:0]  wr_data
);
  import csr_rmw_pkg::*;

  logic              rst_sync_n;
  logic              op_ok;
  logic              mask_nz;
  logic [XLEN-1:0]   wmask;
  logic [XLEN-1:0]   wdata;
  logic [XLEN-1:0]   merged;
  acc_verdict_t      verdict;

  logic              rsp_valid_d, rsp_valid_q;
  logic              rsp_ill_d,   rsp_ill_q;
  logic [XLEN-1:0]   rsp_data_d,  rsp_data_q;
  logic              wr_en_d,     wr_en_q;
  logic [11:0]       wr_addr_d,   wr_addr_q;
  logic [XLEN-1:0]   wr_data_d,   wr_data_q;
  logic              cap_en;

  csr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  csr_op_decode #(.XLEN(XLEN), .IMM_W(IMM_W)) u_dec (
    .op      (req_op),
    .operand (req_operand),
    .uimm    (req_uimm),
    .op_ok   (op_ok),
    .wmask   (wmask),
    .wdata   (wdata),
    .mask_nz (mask_nz)
  );

  csr_access_check u_chk_acc (
    .addr_hi  (req_addr[11:8]),
    .priv     (req_priv),
    .op_ok    (op_ok),
    .mask_nz  (mask_nz),
    .present  (bank_present),
    .writable (bank_writable),
    .rd_fault (bank_rd_fault),
    .wr_fault (bank_wr_fault),
    .verdict  (verdict)
  );

  csr_merge #(.XLEN(XLEN)) u_mrg (
    .old_val (bank_rdata),
    .wmask   (wmask),
    .wdata   (wdata),
    .new_val (merged)
  );

  assign bank_addr = req_addr;

  // next-state
  always_comb begin
    cap_en      = req_valid;
    rsp_valid_d = req_valid;
    rsp_ill_d   = req_valid && verdict.illegal;
    wr_en_d     = req_valid && verdict.do_write;
    rsp_data_d  = verdict.illegal ? '0 : bank_rdata;
    wr_addr_d   = req_addr;
    wr_data_d   = verdict.do_write ? merged : '0;
  end

  // strobes update every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_ill_q   <= 1'b0;
      wr_en_q     <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_ill_q   <= rsp_ill_d;
      wr_en_q     <= wr_en_d;
    end
  end

  // payload captured only with a request
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_data_q <= '0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else if (cap_en) begin
      rsp_data_q <= rsp_data_d;
      wr_addr_q  <= wr_addr_d;
      wr_data_q  <= wr_data_d;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_illegal = rsp_ill_q;
  assign rsp_rdata   = rsp_data_q;
  assign wr_en       = wr_en_q;
  assign wr_addr     = wr_addr_q;
  assign wr_data     = wr_data_q;
endmodule

// File: rtl/csr_rmw_chk.sv
module csr_rmw_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [11:0]      req_addr,
  input logic [1:0]       req_priv,
  input logic [2:0]       req_op,
  input logic [XLEN-1:0]  req_operand,
  input logic [IMM_W-1:0] req_uimm,
  input logic             bank_present,
  input logic             bank_writable,
  input logic             rsp_valid,
  input logic             rsp_illegal,
  input logic             wr_en
);
  logic zero_mask_setclr;
  assign zero_mask_setclr = req_op[1] &&
                            (req_op[2] ? (req_uimm == '0) : (req_operand == '0));

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  low_priv_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_priv < req_addr[9:8])) |=> rsp_illegal);

  // R3
  ro_write_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[11:10] == 2'b11) && (req_op[1:0] == 2'b01)) |=> rsp_illegal);

  // R6
  absent_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bank_present) |=> rsp_illegal);

  // R7
  no_write_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bank_writable) |=> !wr_en);

  // R10
  write_only_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rsp_valid && !rsp_illegal));

  // R10
  zero_mask_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && zero_mask_setclr) |=> !wr_en);

  // R11
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op[1:0] == 2'b00)) |=> rsp_illegal);
endmodule

bind csr_rmw_unit csr_rmw_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_rmw_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_priv      (req_priv),
  .req_op        (req_op),
  .req_operand   (req_operand),
  .req_uimm      (req_uimm),
  .bank_present  (bank_present),
  .bank_writable (bank_writable),
  .rsp_valid     (rsp_valid),
  .rsp_illegal   (rsp_illegal),
  .wr_en         (wr_en)
);

// File: tb/sim_csr_rmw_unit.sv
module sim_csr_rmw_unit;
  localparam int XLEN  = 32;
  localparam int IMM_W = 5;
  localparam logic [31:0] OLD = 32'hA5A5_0F0F;

  typedef struct packed {
    logic [7:0]  req;
    logic [11:0] addr;
    logic [1:0]  priv;
    logic [2:0]  op;
    logic [31:0] operand;
    logic [4:0]  uimm;
    logic [31:0] rdata;
    logic        present;
    logic        writable;
    logic        rdf;
    logic        wrf;
    logic        ill;
    logic        we;
    logic [31:0] wdata;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R4 read-write
    '{8'd4, 12'h300, 2'd3, 3'b001, 32'h1234_5678, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5678},
    // R4 read-set
    '{8'd4, 12'h300, 2'd3, 3'b010, 32'h0000_F0F0, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA5A5_FFFF},
    // R4 read-clear
    '{8'd4, 12'h300, 2'd3, 3'b011, 32'h0000_0F00, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA5A5_000F},
    // R5 immediate write, operand ignored
    '{8'd5, 12'h300, 2'd3, 3'b101, 32'hFFFF_FFFF, 5'h1F, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_001F},
    // R5 immediate set
    '{8'd5, 12'h300, 2'd3, 3'b110, 32'hFFFF_FFFF, 5'h10, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA5A5_0F1F},
    // R5 immediate clear
    '{8'd5, 12'h300, 2'd3, 3'b111, 32'h0000_0000, 5'h0F, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA5A5_0F00},
    // R2 user to supervisor register
    '{8'd2, 12'h100, 2'd0, 3'b010, 32'h0000_0001, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    // R2 supervisor to supervisor register
    '{8'd2, 12'h100, 2'd1, 3'b001, 32'h0000_00FF, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_00FF},
    // R2 supervisor to machine register with zero mask
    '{8'd2, 12'h300, 2'd1, 3'b010, 32'h0000_0000, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    // R3 read-write of read-only, zero operand still full mask
    '{8'd3, 12'hC00, 2'd0, 3'b001, 32'h0000_0000, 5'h00, OLD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    // R3 zero-mask set of read-only is legal
    '{8'd3, 12'hF11, 2'd3, 3'b010, 32'h0000_0000, 5'h00, 32'h0000_0007, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
    // R3 immediate clear of read-only
    '{8'd3, 12'hF11, 2'd3, 3'b111, 32'h0000_0000, 5'h01, OLD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    // R6 absent register
    '{8'd6, 12'h300, 2'd3, 3'b010, 32'h0000_0000, 5'h00, OLD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    // R7 no write path
    '{8'd7, 12'h300, 2'd3, 3'b001, 32'h0000_DEAD, 5'h00, OLD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
    // R8 read fault
    '{8'd8, 12'h300, 2'd3, 3'b010, 32'h0000_0000, 5'h00, OLD, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},
    // R8 write fault on a real write
    '{8'd8, 12'h300, 2'd3, 3'b001, 32'h0000_0001, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},
    // R8 write fault ignored with zero mask
    '{8'd8, 12'h300, 2'd3, 3'b011, 32'h0000_0000, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},
    // R11 reserved opcode 000
    '{8'd11, 12'h300, 2'd3, 3'b000, 32'h0000_0001, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    // R11 reserved opcode 100
    '{8'd11, 12'h300, 2'd3, 3'b100, 32'h0000_0001, 5'h01, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    // R10 immediate set of zero writes nothing
    '{8'd10, 12'h300, 2'd3, 3'b110, 32'hFFFF_FFFF, 5'h00, OLD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0}
  };

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [11:0]      req_addr;
  logic [1:0]       req_priv;
  logic [2:0]       req_op;
  logic [XLEN-1:0]  req_operand;
  logic [IMM_W-1:0] req_uimm;
  logic [11:0]      bank_addr;
  logic [XLEN-1:0]  bank_rdata;
  logic             bank_present;
  logic             bank_writable;
  logic             bank_rd_fault;
  logic             bank_wr_fault;
  logic             rsp_valid;
  logic             rsp_illegal;
  logic [XLEN-1:0]  rsp_rdata;
  logic             wr_en;
  logic [11:0]      wr_addr;
  logic [XLEN-1:0]  wr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  csr_rmw_unit #(.XLEN(XLEN), .IMM_W(IMM_W)) u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid     = 1'b1;
    req_addr      = v.addr;
    req_priv      = v.priv;
    req_op        = v.op;
    req_operand   = v.operand;
    req_uimm      = v.uimm;
    bank_rdata    = v.rdata;
    bank_present  = v.present;
    bank_writable = v.writable;
    bank_rd_fault = v.rdf;
    bank_wr_fault = v.wrf;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_priv = '0; req_op = '0;
    req_operand = '0; req_uimm = '0; bank_rdata = '0; bank_present = 1'b0;
    bank_writable = 1'b0; bank_rd_fault = 1'b0; bank_wr_fault = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 reset rsp_illegal", {31'b0, rsp_illegal}, 32'd0);
    chk("R1 reset wr_en", {31'b0, wr_en}, 32'd0);
    chk("R1 reset rsp_rdata", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk, back to back
    @(negedge clk);
    drive(VECS[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      begin
        vec_t v;
        string tag;
        v = VECS[i];
        tag = $sformatf("R%0d vec %0d", v.req, i);
        chk({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({tag, " illegal"}, {31'b0, rsp_illegal}, {31'b0, v.ill});
        // R9 old value on success, zero on illegal
        chk({tag, " R9 rdata"}, rsp_rdata, v.ill ? 32'd0 : v.rdata);
        // R10 write strobe
        chk({tag, " R10 wr_en"}, {31'b0, wr_en}, {31'b0, v.we});
        if (v.we) begin
          chk({tag, " wr_data"}, wr_data, v.wdata);
          chk({tag, " R10 wr_addr"}, {20'b0, wr_addr}, {20'b0, v.addr});
        end
      end
      if (i + 1 < NV) drive(VECS[i + 1]);
      else req_valid = 1'b0;
    end

    // R1 idle cycle gives no response
    @(negedge clk);
    chk("R1 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10 idle wr_en", {31'b0, wr_en}, 32'd0);

    // R9 old value captured before the write: bank changes after the edge
    drive(VECS[1]);
    @(posedge clk);
    #1 bank_rdata = 32'h0BAD_0BAD;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 old value held", rsp_rdata, OLD);
    chk("R4 merge from sampled old", wr_data, 32'hA5A5_FFFF);

    // R1 reset mid-stream clears outputs
    drive(VECS[0]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset wr_en", {31'b0, wr_en}, 32'd0);
    chk("R1 async reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    req_valid = 1'b0;
    finish_run();
  end
endmodule